// File: doc/BRIEF.md
# MDIO management frame controller

This block drives the management interface of an Ethernet PHY. Software sets an enable bit in a control register and chooses an MDC divide ratio in a configuration register. It then writes one 32-bit maintenance word that holds the whole management transaction. The block shifts out a 32-bit run of ones, then the maintenance word, most significant bit first, on a divided MDC clock. The MDIO pin is split into an output, an output enable and an input, so it can serve as a tri-state pin.

A status register reports idle while no frame is in flight, and software polls it for completion. When the operation field selects a read, the block stops driving MDIO for the turnaround and data bits. It samples the sixteen bits the PHY returns and writes them into the low half of the maintenance register. Software reads the result back from the register it wrote.

Register port: `reg_addr` 0 is control, 1 is configuration, 2 is status and 3 is the maintenance word. Writes take effect at the clock edge where `reg_wr_en` is high. `reg_rdata` shows the register selected by `reg_addr` without a clock delay.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset the block is idle. `mdc` is 0 and `mdio_oe` is 0. The control and maintenance registers read 0, and the configuration register reads 0x000C0000 (divider select 3).
- R2: An accepted maintenance write produces a 64-bit frame on `mdio_o`: 32 ones, then maintenance bits 31 down to 0. One bit is sent per MDC period, and the frame starts in the cycle after the write.
- R3: MDC is the clock divided by the ratio chosen by configuration bits 20:18. The ratios are 0:8, 1:16, 2:32, 3:48, 4:64, 5:96, 6:128 and 7:224. Each MDC half period is ratio/2 clocks. The ratio is latched when a frame starts, and MDC stays low while the block is idle.
- R4: `mdio_o` changes only in the cycle where MDC falls. Read data is sampled in the cycle where MDC rises.
- R5: A write to the maintenance register starts a frame only while control bit 4 is 1. With bit 4 at 0, the word is stored and no frame starts.
- R6: Status bit 2 reads 1 while idle and 0 from the cycle after an accepted start until the falling MDC edge that ends frame bit 63.
- R7: When maintenance bits 29:28 are binary 10 (read), `mdio_oe` is 0 for frame bits 46 to 63, which are the turnaround and the data. For any other operation value, `mdio_oe` is 1 for the whole frame.
- R8: At the end of a read frame, the 16 bits sampled in frame bits 48 to 63, first bit as MSB, replace maintenance bits 15:0. Bits 31:16 keep their values.
- R9: A read with MDIO held high by the pull-up returns 0xFFFF in maintenance bits 15:0.
- R10: A maintenance write while a frame is in flight is ignored. This includes the final cycle of the frame. Such a write neither changes the register nor starts another frame.
- R11: After a frame that is not a read, the maintenance register still holds the word that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The case that needs care is a maintenance write landing on the same edge as the falling MDC edge that ends a read frame. In that cycle, read capture writes the register while the write decode also tries to load it. The bench follows the frame with its own counters and issues the write exactly on that final edge. It then expects the captured data in bits 15:0, the old upper half still in place, and the block back at idle with no second frame. A configuration change made mid-frame is also checked: it must leave the running MDC period unchanged.

// File: rtl/mdio_ctrl_pkg.sv
package mdio_ctrl_pkg;

   typedef enum logic [1:0] {
      ADDR_CTRL  = 2'd0,
      ADDR_CFG   = 2'd1,
      ADDR_STAT  = 2'd2,
      ADDR_MAINT = 2'd3
   } reg_addr_e;

   localparam int WORD_W     = 32;
   localparam int ENABLE_BIT = 4;
   localparam int IDLE_BIT   = 2;
   localparam int DIVSEL_LSB = 18;
   localparam int DIVSEL_W   = 3;
   localparam int OP_LSB     = 28;
   localparam logic [1:0] OP_READ = 2'b10;
   localparam int DATA_W     = 16;
   localparam int TA_W       = 2;

   // MDC divide ratio picked by the configuration select field
   function automatic int unsigned mdc_ratio(input logic [DIVSEL_W-1:0] sel);
      case (sel)
         3'd0:    return 8;
         3'd1:    return 16;
         3'd2:    return 32;
         3'd3:    return 48;
         3'd4:    return 64;
         3'd5:    return 96;
         3'd6:    return 128;
         default: return 224;
      endcase
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [CNT_W-1:0] half_in,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);

   logic [CNT_W-1:0] half_q;
   logic [CNT_W-1:0] cnt_q;
   logic             mdc_q;
   logic             tick;

   initial assert (CNT_W >= 2) else $error("CNT_W too small");

   assign tick = run && (cnt_q == half_q - CNT_W'(1));
   assign rise = tick && !mdc_q;
   assign fall = tick && mdc_q;
   assign mdc  = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q <= CNT_W'(1);
         cnt_q  <= '0;
         mdc_q  <= 1'b0;
      end else if (load) begin
         half_q <= half_in;
         cnt_q  <= '0;
         mdc_q  <= 1'b0;
      end else if (tick) begin
         cnt_q  <= '0;
         mdc_q  <= !mdc_q;
      end else if (run) begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   // MDC parks low whenever no frame runs
   p_mdc_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mdc_q);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
   parameter int PRE_LEN     = 32,
   parameter int WORD_W      = 32,
   parameter int DATA_W      = 16,
   parameter int TA_W        = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   input  logic              is_read,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_i,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              rd_done,
   output logic [DATA_W-1:0] cap_data
);

   localparam int FRAME_LEN = PRE_LEN + WORD_W;
   localparam int BIT_W     = $clog2(FRAME_LEN + 1);
   localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_LEN - 1);
   localparam logic [BIT_W-1:0] REL_FIRST = BIT_W'(FRAME_LEN - DATA_W - TA_W);
   localparam logic [BIT_W-1:0] CAP_FIRST = BIT_W'(FRAME_LEN - DATA_W);

   initial assert (PRE_LEN >= 1 && WORD_W > DATA_W + TA_W)
      else $error("frame geometry invalid");

   logic [FRAME_LEN-1:0] shift_q;
   logic [BIT_W-1:0]     bit_q;
   logic                 busy_q;
   logic                 rd_q;
   logic [DATA_W-1:0]    cap_q;
   logic                 mdio_s;
   logic                 last_fall;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign mdio_s = mdio_i;
      end else begin : g_sync
         logic [SYNC_STAGES:0] chain;
         assign chain[0] = mdio_i;
         for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) chain[g+1] <= 1'b1;
               else        chain[g+1] <= chain[g];
            end
         end
         assign mdio_s = chain[SYNC_STAGES];
      end
   endgenerate

   assign last_fall = busy_q && fall && (bit_q == LAST_BIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '1;
         bit_q   <= '0;
         busy_q  <= 1'b0;
         rd_q    <= 1'b0;
         cap_q   <= '0;
      end else if (busy_q) begin
         if (rise && rd_q && bit_q >= CAP_FIRST)
            cap_q <= {cap_q[DATA_W-2:0], mdio_s};
         if (fall) begin
            shift_q <= {shift_q[FRAME_LEN-2:0], 1'b1};
            bit_q   <= bit_q + BIT_W'(1);
            if (bit_q == LAST_BIT) busy_q <= 1'b0;
         end
      end else if (start) begin
         shift_q <= {{PRE_LEN{1'b1}}, word};
         bit_q   <= '0;
         busy_q  <= 1'b1;
         rd_q    <= is_read;
         cap_q   <= '0;
      end
   end

   assign busy     = busy_q;
   assign mdio_o   = busy_q ? shift_q[FRAME_LEN-1] : 1'b1;
   assign mdio_oe  = busy_q && !(rd_q && bit_q >= REL_FIRST);
   assign rd_done  = last_fall && rd_q;
   assign cap_data = cap_q;

   // line value moves only on a falling MDC edge
   p_shift_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fall) |=> $stable(mdio_o));

   // PHY owns the line when read data is sampled
   p_no_drive_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rd_q && rise && bit_q >= CAP_FIRST) |-> !mdio_oe);

   // the final falling edge returns the block to idle
   p_done_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last_fall |=> !busy_q);

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
   import mdio_ctrl_pkg::*;
#(
   parameter int PRE_LEN     = 32,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 0,
   parameter int DIVSEL_RST  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   localparam logic [WORD_W-1:0] CFG_RST =
      WORD_W'(DIVSEL_RST) << DIVSEL_LSB;

   initial assert (224 / 2 < (1 << CNT_W)) else $error("CNT_W cannot hold half period");
   initial assert (DIVSEL_RST >= 0 && DIVSEL_RST < (1 << DIVSEL_W))
      else $error("DIVSEL_RST out of range");

   logic [WORD_W-1:0] ctrl_q, cfg_q, maint_q;
   logic              wr_maint, start, busy, rd_done, rise, fall;
   logic [DATA_W-1:0] cap;
   logic [CNT_W-1:0]  half;

   assign wr_maint = reg_wr_en && (reg_addr == ADDR_MAINT);
   assign start    = wr_maint && !busy && ctrl_q[ENABLE_BIT];
   assign half     = CNT_W'(mdc_ratio(cfg_q[DIVSEL_LSB +: DIVSEL_W]) / 2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cfg_q   <= CFG_RST;
         maint_q <= '0;
      end else begin
         if (reg_wr_en && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata;
         if (reg_wr_en && reg_addr == ADDR_CFG)  cfg_q  <= reg_wdata;
         if (wr_maint && !busy)
            maint_q <= reg_wdata;
         else if (rd_done)
            maint_q[DATA_W-1:0] <= cap;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: reg_rdata = ctrl_q;
         ADDR_CFG:  reg_rdata = cfg_q;
         ADDR_STAT: reg_rdata[IDLE_BIT] = !busy;
         default:   reg_rdata = maint_q;
      endcase
   end

   mdio_mdc_gen #(.CNT_W(CNT_W)) u_mdc (
      .clk(clk), .rst_n(rst_n), .load(start), .run(busy),
      .half_in(half), .mdc(mdc), .rise(rise), .fall(fall)
   );

   mdio_frame_seq #(
      .PRE_LEN(PRE_LEN), .WORD_W(WORD_W), .DATA_W(DATA_W),
      .TA_W(TA_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .word(reg_wdata),
      .is_read(reg_wdata[OP_LSB +: 2] == OP_READ),
      .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(busy),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_done(rd_done), .cap_data(cap)
   );

   // a frame begins only after an enabled maintenance write
   p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_maint && ctrl_q[ENABLE_BIT]));

   // writes during a frame leave the word alone
   p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_maint && busy && !rd_done) |=> $stable(maint_q));

endmodule

// File: tb/mdio_frame_ctrl_tb_top.sv
module mdio_frame_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_addr = 2'd2;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_frame_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // ---------------- reference model ----------------
   int          m_hc, m_half, m_bit;
   bit          m_busy, m_mdc, m_rd;
   logic [31:0] m_ctrl, m_cfg, m_maint;
   logic [63:0] m_frame;
   logic [15:0] m_cap;
   logic [15:0] phy_resp = 16'hFFFF;

   function automatic int ratio_of(input logic [2:0] s);
      int t[8] = '{8, 16, 32, 48, 64, 96, 128, 224};
      return t[s];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hc = 0; m_half = 1; m_bit = 0; m_busy = 0; m_mdc = 0; m_rd = 0;
         m_ctrl = 0; m_cfg = 32'h000C0000; m_maint = 0; m_frame = '1; m_cap = 0;
      end else begin
         if (m_busy) begin
            if (m_hc == m_half - 1) begin
               m_hc = 0;
               if (!m_mdc) begin
                  m_mdc = 1;
                  if (m_rd && m_bit >= 48) m_cap = {m_cap[14:0], mdio_i};
               end else begin
                  m_mdc = 0;
                  m_bit++;
                  if (m_bit == 64) begin
                     m_busy = 0;
                     if (m_rd) m_maint[15:0] = m_cap;
                  end
               end
            end else m_hc++;
         end else if (reg_wr_en && reg_addr == 2'd3) begin
            m_maint = reg_wdata;
            if (m_ctrl[4]) begin
               m_busy = 1; m_bit = 0; m_hc = 0; m_mdc = 0; m_cap = 0;
               m_rd = (reg_wdata[29:28] == 2'b10);
               m_half = ratio_of(m_cfg[20:18]) / 2;
               m_frame = {32'hFFFFFFFF, reg_wdata};
            end
         end
         if (reg_wr_en && reg_addr == 2'd0) m_ctrl = reg_wdata;
         if (reg_wr_en && reg_addr == 2'd1) m_cfg  = reg_wdata;
      end
   end

   // PHY stand-in: echoes the line while the block drives, else returns data
   always @(negedge clk) begin
      if (mdio_oe)                   mdio_i <= mdio_o;
      else if (m_busy && m_bit >= 48) mdio_i <= phy_resp[63 - m_bit];
      else                            mdio_i <= 1'b1;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // ---------------- per-cycle comparison ----------------
   logic p_mdc = 0, p_o = 1, p_oe = 0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk(mdc == m_mdc, "R3 mdc", mdc, m_mdc);
         chk(mdio_oe == (m_busy && !(m_rd && m_bit >= 46)), "R7 mdio_oe", mdio_oe,
             m_busy && !(m_rd && m_bit >= 46));
         if (mdio_oe && m_bit < 64)
            chk(mdio_o == m_frame[63 - m_bit], "R2 mdio_o", mdio_o, m_frame[63 - m_bit]);
         if (reg_addr == 2'd2)
            chk(reg_rdata[2] == !m_busy, "R6 idle bit", reg_rdata[2], !m_busy);
         if (mdio_oe && p_oe && mdio_o != p_o)
            chk(p_mdc && !mdc, "R4 change off falling edge", {p_mdc, mdc}, 2'b10);
      end
      p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
   end

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
         summary();
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr_en = 0; reg_addr = 2'd2;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #2; d = reg_rdata;
      @(negedge clk); reg_addr = 2'd2;
   endtask

   task automatic wait_idle;
      @(negedge clk);
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] mkw(input logic [1:0] op, input logic [4:0] ph,
                                       input logic [4:0] rg, input logic [15:0] dt);
      return {2'b01, op, ph, rg, 2'b10, dt};
   endfunction

   logic [31:0] v, w;
   int          rises;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(2'd0, v); chk(v == 0, "R1 control", v, 0);
      rd(2'd1, v); chk(v == 32'h000C0000, "R1 config", v, 32'h000C0000);
      rd(2'd3, v); chk(v == 0, "R1 maint", v, 0);
      rd(2'd2, v); chk(v == 32'h4, "R1 status", v, 32'h4);
      chk(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);

      // R5 no frame while port disabled
      w = mkw(2'b01, 5'd7, 5'd2, 16'h0F0F);
      wr(2'd3, w);
      rises = 0;
      repeat (200) begin @(negedge clk); if (mdc) rises++; end
      chk(rises == 0, "R5 mdc quiet when disabled", rises, 0);
      rd(2'd2, v); chk(v[2], "R5 still idle", v, 32'h4);
      rd(2'd3, v); chk(v == w, "R5 word stored", v, w);

      // R11/R10 write frame at /48, second write mid-frame ignored
      wr(2'd0, 32'h10);
      w = mkw(2'b01, 5'd3, 5'd1, 16'hA5C3);
      wr(2'd3, w);
      repeat (500) @(negedge clk);
      wr(2'd3, mkw(2'b10, 5'd9, 5'd9, 16'h1111));
      wait_idle();
      rd(2'd3, v); chk(v == w, "R11 R10 maint after write frame", v, w);
      rises = 0;
      repeat (100) begin @(negedge clk); if (mdc) rises++; end
      chk(rises == 0, "R10 no second frame", rises, 0);

      // R8 read at /64 with PHY data
      wr(2'd1, 32'h4 << 18);
      phy_resp = 16'h1234;
      w = mkw(2'b10, 5'd1, 5'd1, 16'h0000);
      wr(2'd3, w);
      wait_idle();
      rd(2'd3, v); chk(v == {w[31:16], 16'h1234}, "R8 read capture", v, {w[31:16], 16'h1234});

      // R9 + R10 collision: read with no PHY, write on the final edge
      wr(2'd1, 32'h3 << 18);
      phy_resp = 16'hFFFF;
      w = mkw(2'b10, 5'd31, 5'd1, 16'h0000);
      wr(2'd3, w);
      @(negedge clk);
      while (!(m_busy && m_bit == 63 && m_mdc && m_hc == m_half - 1)) @(negedge clk);
      reg_wr_en = 1; reg_addr = 2'd3; reg_wdata = 32'hDEADBEEF;
      @(negedge clk); reg_wr_en = 0; reg_addr = 2'd2;
      #2; chk(reg_rdata[2], "R10 idle after final-edge write", reg_rdata, 32'h4);
      wait_idle();
      rd(2'd3, v); chk(v == {w[31:16], 16'hFFFF}, "R9 R10 no-PHY read", v, {w[31:16], 16'hFFFF});

      // R3 config change mid-frame keeps running period; model compares each cycle
      phy_resp = 16'hBEEF;
      w = mkw(2'b10, 5'd4, 5'd5, 16'h0000);
      wr(2'd3, w);
      repeat (300) @(negedge clk);
      wr(2'd1, 32'h0 << 18);
      wait_idle();
      rd(2'd3, v); chk(v == {w[31:16], 16'hBEEF}, "R3 R8 read after cfg change", v, {w[31:16], 16'hBEEF});

      // R3 fast ratio 8, write op 11 holds oe
      w = {2'b01, 2'b11, 5'd2, 5'd3, 2'b10, 16'h5AA5};
      wr(2'd3, w);
      wait_idle();
      rd(2'd3, v); chk(v == w, "R11 R7 non-read op", v, w);

      summary();
   end

endmodule